// File: doc/BRIEF.md
# Motion Delta Accumulator with Host Interrupt

This block sits between a per-frame motion estimator and the register interface of a navigation sensor. Each frame the estimator may present a signed X and Y displacement with a valid strobe. The block adds these displacements into two 8-bit two's-complement delta registers that clamp at their limits. It also keeps a motion status flag. The host reads the deltas, and each read empties the register it reads. A write to the status location discards all pending motion at once.

An interrupt pin tells the host that motion is waiting. A small configuration register sets the pin's active level and picks one of two signalling styles. In level style the pin stays active while motion is pending. In edge style the pin gives one fixed-length pulse when motion is seen while the sensor is in a low-power rest state. The pulse length is a parameter in clock cycles, and a pulse that is already running is never lengthened.

Top module: `motion_irq_top`

## Requirements
- R1: On each cycle with `frame_vld` high, each delta register takes the sum of its value and the input displacement, both two's complement. The sum clamps to +127 (0x7F) and -128 (0x80) instead of wrapping.
- R2: A read strobe on `rd_dx` or `rd_dy` returns the register value on `delta_x`/`delta_y` in that cycle and clears the register at the clock edge. If a frame arrives in the same cycle, the register holds exactly that frame's displacement.
- R3: `stat_byte` carries the motion flag in bit 7, and bits 6..0 are always 0. A frame whose X or Y displacement is nonzero sets the flag. A status read (`rd_stat`) leaves the flag unchanged.
- R4: A status write (`wr_stat`) clears both deltas and the flag, and nothing of the written value is kept. A nonzero frame in the same cycle is loaded into the cleared deltas, and the flag stays set.
- R5: With no nonzero frame, a delta read that leaves both deltas at zero clears the flag. A read that leaves the other delta nonzero keeps the flag set.
- R6: The configuration register resets to 0x40 and is written by `cfg_wr` with `cfg_wdata`. Bit 7 selects the active level (1 = active high, 0 = active low). Bit 6 selects edge style (1) or level style (0). Bits 5..0 are ignored. After reset the pin is therefore inactive, which means high.
- R7: In level style the pin is at its active level exactly while the motion flag is set.
- R8: In edge style, a nonzero frame with `in_rest` high starts a pulse at the active level of exactly PULSE_CYC cycles. A nonzero frame with `in_rest` low gives no pulse. Outside a pulse the pin is inactive.
- R9: A nonzero rest-state frame during a running pulse neither extends nor restarts it.
- R10: A frame with both displacements zero changes neither the flag, the deltas nor the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | Frame displacement valid |
| frame_dx | input | IN_W | Frame X displacement, two's complement |
| frame_dy | input | IN_W | Frame Y displacement, two's complement |
| in_rest | input | 1 | High while the sensor is in a rest state |
| rd_stat | input | 1 | Host read of the status location |
| rd_dx | input | 1 | Host read of delta X (clears it) |
| rd_dy | input | 1 | Host read of delta Y (clears it) |
| wr_stat | input | 1 | Host write to the status location (clears all) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| delta_x | output | DW | Accumulated X displacement |
| delta_y | output | DW | Accumulated Y displacement |
| stat_byte | output | 8 | Status value, flag in bit 7 |
| irq_pin | output | 1 | Interrupt pin toward the host |

## Verification
The collision that matters is a host clear and a new frame landing in the same cycle. This can be a delta read or a status write. The bench drives `frame_vld` together with `rd_dx`, `rd_dy` or `wr_stat` in one cycle. On the next falling edge it expects the register to hold only the new displacement and the flag to stay set. A second collision is a rest-state motion frame arriving in the middle of an edge pulse. The bench judges it by comparing the pulse's total length against PULSE_CYC cycles from its start. A reference model in the bench, built from the requirement text, is compared on every cycle of a near-exhaustive sweep of start values and displacements.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;
  localparam int CFG_POL_BIT  = 7;
  localparam int CFG_MODE_BIT = 6;
  localparam logic [7:0] CFG_RESET = 8'h40;
  localparam int STAT_FLAG_BIT = 7;

  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_EDGE  = 1'b1
  } irq_mode_e;

  function automatic logic any_nonzero(input logic [31:0] a, input logic [31:0] b);
    return (a != 32'd0) || (b != 32'd0);
  endfunction
endpackage

// File: rtl/mi_axis_acc.sv
module mi_axis_acc #(
  parameter int DW   = 8,
  parameter int IN_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [IN_W-1:0] d,
  input  logic            clr,
  output logic [DW-1:0]   acc,
  output logic            zero_nxt
);
  localparam int SW = ((DW > IN_W) ? DW : IN_W) + 1;
  localparam logic [DW-1:0] HI_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] LO_D = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [SW-1:0] HI_S = SW'(signed'(HI_D));
  localparam logic signed [SW-1:0] LO_S = SW'(signed'(LO_D));

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a, input logic [IN_W-1:0] b);
    logic signed [SW-1:0] s;
    s = SW'(signed'(a)) + SW'(signed'(b));
    if (s > HI_S) return HI_D;
    if (s < LO_S) return LO_D;
    return s[DW-1:0];
  endfunction

  logic [DW-1:0] base, nxt;

  always_comb begin
    base = clr ? '0 : acc;
    nxt  = ld ? sat_add(base, d) : base;
  end

  assign zero_nxt = (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= nxt;
  end

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> (acc == '0));
  // R1
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr && acc == HI_D && !d[IN_W-1]) |=> (acc == HI_D));
  // R1
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr && acc == LO_D && d[IN_W-1]) |=> (acc == LO_D));
endmodule

// File: rtl/mi_status.sv
module mi_status (
  input  logic clk,
  input  logic rst_n,
  input  logic motion,
  input  logic wr_clr,
  input  logic dl_rd,
  input  logic st_rd,
  input  logic both_zero_nxt,
  output logic st
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      st <= 1'b0;
    else if (motion)                 st <= 1'b1;
    else if (wr_clr)                 st <= 1'b0;
    else if (dl_rd && both_zero_nxt) st <= 1'b0;
  end

  // R3
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    motion |=> st);
  // R3
  stat_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && st && !wr_clr && !dl_rd) |=> st);
  // R4
  stat_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !motion) |=> !st);
endmodule

// File: rtl/mi_irq_gen.sv
module mi_irq_gen #(
  parameter int PULSE_CYC = 28750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic pol,
  input  logic st,
  input  logic trig,
  output logic pulse_on,
  output logic pin
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (!edge_mode) cnt <= '0;
    else if (cnt != '0) cnt <= cnt - 1'b1;
    else if (trig)      cnt <= LOAD;
  end

  assign pulse_on = (cnt != '0);
  assign active   = edge_mode ? pulse_on : st;
  assign pin      = pol ? active : !active;

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !pulse_on && trig) |=> (cnt == LOAD));
  // R9
  pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pulse_on) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/motion_irq_top.sv
module motion_irq_top
  import motion_irq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IN_W      = 8,
  parameter int PULSE_CYC = 28750
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_vld,
  input  logic [IN_W-1:0] frame_dx,
  input  logic [IN_W-1:0] frame_dy,
  input  logic            in_rest,
  input  logic            rd_stat,
  input  logic            rd_dx,
  input  logic            rd_dy,
  input  logic            wr_stat,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  output logic [DW-1:0]   delta_x,
  output logic [DW-1:0]   delta_y,
  output logic [7:0]      stat_byte,
  output logic            irq_pin
);
  localparam int NAX = 2;

  logic            pol_q;
  irq_mode_e       mode_q;
  logic [IN_W-1:0] ax_d   [NAX];
  logic            ax_clr [NAX];
  logic [DW-1:0]   ax_acc [NAX];
  logic            ax_zero[NAX];
  logic            motion, trig, both_zero_nxt, st, pulse_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= CFG_RESET[CFG_POL_BIT];
      mode_q <= irq_mode_e'(CFG_RESET[CFG_MODE_BIT]);
    end else if (cfg_wr) begin
      pol_q  <= cfg_wdata[CFG_POL_BIT];
      mode_q <= irq_mode_e'(cfg_wdata[CFG_MODE_BIT]);
    end
  end

  assign motion = frame_vld && any_nonzero(32'(frame_dx), 32'(frame_dy));
  assign trig   = motion && in_rest;

  assign ax_d[0]   = frame_dx;
  assign ax_d[1]   = frame_dy;
  assign ax_clr[0] = rd_dx || wr_stat;
  assign ax_clr[1] = rd_dy || wr_stat;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    mi_axis_acc #(.DW(DW), .IN_W(IN_W)) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (frame_vld),
      .d        (ax_d[g]),
      .clr      (ax_clr[g]),
      .acc      (ax_acc[g]),
      .zero_nxt (ax_zero[g])
    );
  end

  assign both_zero_nxt = ax_zero[0] && ax_zero[1];

  mi_status status_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .motion        (motion),
    .wr_clr        (wr_stat),
    .dl_rd         (rd_dx || rd_dy),
    .st_rd         (rd_stat),
    .both_zero_nxt (both_zero_nxt),
    .st            (st)
  );

  mi_irq_gen #(.PULSE_CYC(PULSE_CYC)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (mode_q == IRQ_EDGE),
    .pol       (pol_q),
    .st        (st),
    .trig      (trig),
    .pulse_on  (pulse_on),
    .pin       (irq_pin)
  );

  assign delta_x   = ax_acc[0];
  assign delta_y   = ax_acc[1];
  assign stat_byte = {st, 7'b0};

  // R5
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_dx || rd_dy) && !motion && both_zero_nxt) |=> !st);
  // R6
  cfg_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_wdata[5:0] != 6'd0) && !cfg_wdata[CFG_MODE_BIT]) |=> !pulse_on);
  // R10
  zero_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !motion && !rd_dx && !rd_dy && !wr_stat && !rd_stat) |=> $stable(st));
endmodule

// File: tb/motion_irq_top_tb_top.sv
`timescale 1ns/1ps
module motion_irq_top_tb_top;
  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_vld = 0, in_rest = 0, rd_stat = 0, rd_dx = 0, rd_dy = 0;
  logic       wr_stat = 0, cfg_wr = 0;
  logic [7:0] frame_dx = 0, frame_dy = 0, cfg_wdata = 0;
  logic [7:0] delta_x, delta_y, stat_byte;
  logic       irq_pin;

  int n_chk = 0, n_bad = 0;
  int mx = 0, my = 0, mpc = 0;
  bit mst = 0, mpol = 0, medge = 1, done = 0;

  always #4 clk = ~clk;

  motion_irq_top #(.DW(8), .IN_W(8), .PULSE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_dx(frame_dx),
    .frame_dy(frame_dy), .in_rest(in_rest), .rd_stat(rd_stat), .rd_dx(rd_dx),
    .rd_dy(rd_dy), .wr_stat(wr_stat), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .delta_x(delta_x), .delta_y(delta_y), .stat_byte(stat_byte), .irq_pin(irq_pin)
  );

  function automatic int clamp(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int ep;
    ep = medge ? ((mpc != 0) ? mpol : !mpol) : (mst ? mpol : !mpol);
    chk(tag, "delta_x", int'($signed(delta_x)), mx);
    chk(tag, "delta_y", int'($signed(delta_y)), my);
    chk(tag, "stat_byte", int'(stat_byte), mst ? 128 : 0);
    chk(tag, "irq_pin", int'(irq_pin), ep);
  endtask

  // one clock: drive after a falling edge, update the model, check at the next falling edge
  task automatic cyc(input string tag, input bit fv, input int dx, input int dy,
                     input bit rx, input bit ry, input bit rs, input bit ws,
                     input bit cw, input int cd, input bit rest);
    bit mot, eold;
    frame_vld = fv; frame_dx = dx[7:0]; frame_dy = dy[7:0];
    rd_dx = rx; rd_dy = ry; rd_stat = rs; wr_stat = ws;
    cfg_wr = cw; cfg_wdata = cd[7:0]; in_rest = rest;
    mot  = fv && (dx != 0 || dy != 0);
    eold = medge;
    if (rx || ws) mx = 0;
    if (ry || ws) my = 0;
    if (fv) begin mx = clamp(mx + dx); my = clamp(my + dy); end
    if (mot) mst = 1;
    else if (ws) mst = 0;
    else if ((rx || ry) && mx == 0 && my == 0) mst = 0;
    if (!eold) mpc = 0;
    else if (mpc != 0) mpc--;
    else if (mot && rest) mpc = P;
    if (cw) begin mpol = cd[7]; medge = cd[6]; end
    @(negedge clk);
    frame_vld = 0; rd_dx = 0; rd_dy = 0; rd_stat = 0; wr_stat = 0; cfg_wr = 0;
    check_all(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R6 reset");

    // R1 sweep of start values and steps, clamping included
    for (int a = -128; a <= 127; a += 15) begin
      for (int d = -128; d <= 127; d += 17) begin
        cyc("R4 clear", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R1 load", 1, a, d, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1 sum", 1, d, a, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1 sum2", 1, d, d, 0, 0, 0, 0, 0, 0, 0);
      end
    end
    cyc("R1 hi", 1, 127, -128, 0, 0, 0, 1, 0, 0, 0);
    cyc("R1 hi hold", 1, 127, -128, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 hi back", 1, -1, 1, 0, 0, 0, 0, 0, 0, 0);

    // R2 read clears, read with frame loads the frame
    cyc("R4 clear", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R2 setup", 1, 40, -30, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 read x with frame", 1, -7, 5, 1, 0, 0, 0, 0, 0, 0);
    cyc("R2 read y with frame", 1, 3, 9, 0, 1, 0, 0, 0, 0, 0);
    cyc("R2 read x", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);

    // R3 status read keeps flag
    cyc("R3 stat read", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R3 stat read again", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R5 read to empty clears flag
    cyc("R5 read y empty", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R5 new motion", 1, 2, 4, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5 read x, y left", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R5 read y", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    // R4 write with frame in same cycle
    cyc("R4 fill", 1, 60, 60, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 write with frame", 1, -3, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R4 write alone", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);

    // R10 zero frames
    cyc("R10 zero frame", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R10 zero frame", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R10 idle", 2);

    // R7 level style, active low then active high
    cyc("R7 cfg level low", 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    cyc("R7 motion", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 read x", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7 cfg level high", 0, 0, 0, 0, 0, 0, 0, 1, 8'h80, 0);
    cyc("R7 motion hi", 1, 0, -1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 read y", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    // R6 spare bits ignored: 0x3F is level, active low
    cyc("R6 cfg spare", 0, 0, 0, 0, 0, 0, 0, 1, 8'h3F, 0);
    cyc("R6 motion", 1, 5, 5, 0, 0, 0, 0, 0, 0, 1);
    cyc("R6 clear", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);

    // R8 edge style active high: run-mode motion gives no pulse, rest motion gives P cycles
    cyc("R8 cfg edge high", 0, 0, 0, 0, 0, 0, 0, 1, 8'hC0, 0);
    cyc("R8 run motion", 1, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R8 no pulse", 3);
    cyc("R8 rest motion", 1, 0, 2, 0, 0, 0, 0, 0, 0, 1);
    idle("R8 pulse", P + 3);
    cyc("R8 cfg edge low", 0, 0, 0, 0, 0, 0, 0, 1, 8'h40, 0);
    cyc("R8 rest motion low", 1, -2, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R8 pulse low", P + 2);

    // R9 motion during a pulse does not extend it
    cyc("R9 start", 1, 1, 1, 0, 0, 0, 0, 0, 0, 1);
    idle("R9 mid", 4);
    cyc("R9 retrigger", 1, 3, 3, 0, 0, 0, 0, 0, 0, 1);
    idle("R9 tail", P);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule